// File: doc/BRIEF.md
# Transmit Channel Signaling and Octet Conditioner

This block serves the transmit side of a single T1 or E1 channel. It holds a four-bit ABCD robbed-bit signaling buffer. Incoming signaling bits load into that buffer under the control of a one-cycle update strobe. The load rule depends on the line mode and on an AB-only control.

On the same path, the block conditions the outgoing channel octet and the embedded framing bit. In T1 mode it can apply bit-7 zero-code substitution to an assigned slot. It can also force the embedded F-bit of an idle, unassigned slot to a programmed level.

All configuration arrives as static per-channel inputs. The conditioning is combinational and takes effect in the cycle the octet is presented.

Top module: `tx_chan_cond`

## Requirements
- R1: In T1 mode (`modeE1`=0), an update strobe loads A and B from `sigIn[3]` and `sigIn[2]` into buffer bits 3 and 2, and C and D (buffer bits 1 and 0) keep their values. The buffer is shown on `sigOut` one cycle after the strobe.
- R2: In T1 mode with `sigFreeze`=1, `sigOut[1]` equals `sigOut[3]` and `sigOut[0]` equals `sigOut[2]`. Freeze does not alter the stored buffer.
- R3: In E1 mode with `abOnly`=1, an update loads A and B from the input and writes C=0 and D=1, so the buffer becomes {sigIn[3:2],2'b01}.
- R4: In E1 mode with `abOnly`=0, an update loads all four bits from `sigIn`. Freeze has no effect on `sigOut` in E1 mode.
- R5: The buffer resets to 4'b0000 and changes only in a cycle where `sigUpd` is high.
- R6: Bits are numbered 1 (MSB, `octetIn[7]`) to 8 (LSB). Take a T1 slot with `slotAssigned`=1 and `zeroSupEn`=1. If `octetIn` is all zeros, `octetOut` is 8'h02 (bit 7 = `octetOut[1]` set). In every other case `octetOut` equals `octetIn`.
- R7: In T1 mode with `slotAssigned`=0 and `slotIdle`=1, `fbitOut` equals `fbitVal`. Otherwise `fbitOut` passes `fbitIn` through.
- R8: In E1 mode, `octetOut` equals `octetIn` and `fbitOut` equals `fbitIn`, whatever the zero-suppression and idle settings are.
- R9: Octet and F-bit conditioning are combinational. They reflect the present inputs with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeE1 | input | 1 | 1 = E1 line mode, 0 = T1 |
| abOnly | input | 1 | AB-only signaling control |
| sigFreeze | input | 1 | Signaling freeze |
| slotAssigned | input | 1 | Slot is assigned to a line channel |
| slotIdle | input | 1 | Idle flag for the slot |
| zeroSupEn | input | 1 | Bit-7 zero-code substitution enable |
| fbitVal | input | 1 | Programmed embedded F-bit level |
| sigUpd | input | 1 | One-cycle signaling buffer update strobe |
| sigIn | input | 4 | Incoming ABCD signaling, A in bit 3 |
| octetIn | input | 8 | Outgoing channel octet before conditioning |
| fbitIn | input | 1 | Embedded F-bit before override |
| sigOut | output | 4 | Buffered ABCD signaling, A in bit 3 |
| octetOut | output | 8 | Conditioned channel octet |
| fbitOut | output | 1 | Embedded F-bit after override |

## Verification
A signaling update and the T1 freeze mirror can land in the same cycle. The bench raises `sigUpd` while `sigFreeze` is held high in T1 mode. It then expects the next-cycle `sigOut` to show the freshly loaded A and B on both halves, while the untouched C and D stay hidden in the buffer. That claim is settled once freeze drops and the stored C and D reappear. The bench also raises `sigUpd` together with an all-zero octet on an assigned slot. In that case the substituted octet and the new signaling must both be correct in one sampled cycle.

// File: rtl/tx_sig_pkg.sv
package tx_sig_pkg;
  localparam int SIG_W  = 4;
  localparam int OCT_W  = 8;
  localparam int B7_POS = OCT_W - 7;     // bit 7 counted from MSB=1
  localparam logic [1:0] E1_CD_FILL = 2'b01;

  typedef struct packed {
    logic wrAB;
    logic wrCD;
    logic cdFixed;
    logic mirrorCD;
    logic subB7;
    logic forceF;
  } ctlStrobes_t;
endpackage

// File: rtl/tx_sig_ctrl.sv
module tx_sig_ctrl
  import tx_sig_pkg::*;
(
  input  logic        modeE1,
  input  logic        abOnly,
  input  logic        sigFreeze,
  input  logic        slotAssigned,
  input  logic        slotIdle,
  input  logic        zeroSupEn,
  input  logic        sigUpd,
  input  logic        octetZero,
  output ctlStrobes_t strobes
);
  logic isT1;
  assign isT1 = ~modeE1;

  always_comb begin
    strobes          = '0;
    strobes.wrAB     = sigUpd;
    strobes.wrCD     = sigUpd & modeE1;
    strobes.cdFixed  = modeE1 & abOnly;
    strobes.mirrorCD = isT1 & sigFreeze;
    strobes.subB7    = isT1 & slotAssigned & zeroSupEn & octetZero;
    strobes.forceF   = isT1 & ~slotAssigned & slotIdle;
  end
endmodule

// File: rtl/tx_sig_dp.sv
module tx_sig_dp
  import tx_sig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [SIG_W-1:0]  sigIn,
  input  logic [OCT_W-1:0]  octetIn,
  input  logic              fbitIn,
  input  logic              fbitVal,
  output logic              octetZero,
  output logic [SIG_W-1:0]  sigOut,
  output logic [OCT_W-1:0]  octetOut,
  output logic              fbitOut
);
  localparam int HALF = SIG_W / 2;

  logic [HALF-1:0] abReg, cdReg, cdNext;

  assign cdNext = strobes.cdFixed ? E1_CD_FILL : sigIn[HALF-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abReg <= '0;
      cdReg <= '0;
    end else begin
      if (strobes.wrAB) abReg <= sigIn[SIG_W-1:HALF];
      if (strobes.wrCD) cdReg <= cdNext;
    end
  end

  assign sigOut = strobes.mirrorCD ? {abReg, abReg} : {abReg, cdReg};

  assign octetZero = ~|octetIn;

  for (genvar b = 0; b < OCT_W; b++) begin : g_oct
    if (b == B7_POS) begin : g_sub
      assign octetOut[b] = octetIn[b] | strobes.subB7;
    end else begin : g_pass
      assign octetOut[b] = octetIn[b];
    end
  end

  assign fbitOut = strobes.forceF ? fbitVal : fbitIn;
endmodule

// File: rtl/tx_chan_cond.sv
module tx_chan_cond
  import tx_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeE1,
  input  logic             abOnly,
  input  logic             sigFreeze,
  input  logic             slotAssigned,
  input  logic             slotIdle,
  input  logic             zeroSupEn,
  input  logic             fbitVal,
  input  logic             sigUpd,
  input  logic [3:0]       sigIn,
  input  logic [7:0]       octetIn,
  input  logic             fbitIn,
  output logic [3:0]       sigOut,
  output logic [7:0]       octetOut,
  output logic             fbitOut
);
  ctlStrobes_t strobes;
  logic        octetZero;

  tx_sig_ctrl u_ctrl (
    .modeE1(modeE1), .abOnly(abOnly), .sigFreeze(sigFreeze),
    .slotAssigned(slotAssigned), .slotIdle(slotIdle),
    .zeroSupEn(zeroSupEn), .sigUpd(sigUpd),
    .octetZero(octetZero), .strobes(strobes)
  );

  tx_sig_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sigIn(sigIn), .octetIn(octetIn), .fbitIn(fbitIn), .fbitVal(fbitVal),
    .octetZero(octetZero), .sigOut(sigOut), .octetOut(octetOut),
    .fbitOut(fbitOut)
  );
endmodule

// File: rtl/tx_sig_chk.sv
module tx_sig_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeE1,
  input logic       abOnly,
  input logic       sigFreeze,
  input logic       slotAssigned,
  input logic       slotIdle,
  input logic       zeroSupEn,
  input logic       fbitVal,
  input logic       sigUpd,
  input logic [3:0] sigIn,
  input logic [7:0] octetIn,
  input logic       fbitIn,
  input logic [3:0] sigOut,
  input logic [7:0] octetOut,
  input logic       fbitOut
);
  logic showBuf;
  assign showBuf = modeE1 | ~sigFreeze;

  a_r1_t1_ab_load: assert property (@(posedge clk) disable iff (!rstN)
    (sigUpd && !modeE1) |=> sigOut[3:2] == $past(sigIn[3:2]));

  a_r1_t1_cd_keep: assert property (@(posedge clk) disable iff (!rstN)
    (sigUpd && !modeE1 && showBuf) |=> (showBuf -> sigOut[1:0] == $past(sigOut[1:0])));

  a_r2_freeze_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (!modeE1 && sigFreeze) |-> (sigOut[1:0] == sigOut[3:2]));

  a_r3_e1_ab_fill: assert property (@(posedge clk) disable iff (!rstN)
    (sigUpd && modeE1 && abOnly) |=> (showBuf -> sigOut == {$past(sigIn[3:2]), 2'b01}));

  a_r4_e1_full_load: assert property (@(posedge clk) disable iff (!rstN)
    (sigUpd && modeE1 && !abOnly) |=> (showBuf -> sigOut == $past(sigIn)));

  a_r5_hold_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!sigUpd && modeE1) |=> (modeE1 -> $stable(sigOut)));

  a_r6_zero_sub: assert property (@(posedge clk) disable iff (!rstN)
    (!modeE1 && slotAssigned && zeroSupEn && octetIn == 8'h00) |-> octetOut == 8'h02);

  a_r7_fbit_force: assert property (@(posedge clk) disable iff (!rstN)
    (!modeE1 && !slotAssigned && slotIdle) |-> fbitOut == fbitVal);

  a_r8_e1_pass: assert property (@(posedge clk) disable iff (!rstN)
    modeE1 |-> (octetOut == octetIn && fbitOut == fbitIn));
endmodule

bind tx_chan_cond tx_sig_chk u_chk (.*);

// File: tb/sim_tx_chan_cond.sv
module sim_tx_chan_cond;
  localparam int CLK_PER = 10;

  typedef struct {
    logic [3:0] sig;
    logic [7:0] oct;
    logic       fb;
    string      tag;
  } expItem_t;

  logic clk = 0, rstN = 0;
  logic modeE1 = 0, abOnly = 0, sigFreeze = 0, slotAssigned = 0, slotIdle = 0;
  logic zeroSupEn = 0, fbitVal = 0, sigUpd = 0, fbitIn = 0;
  logic [3:0] sigIn = '0;
  logic [7:0] octetIn = '0;
  logic [3:0] sigOut;
  logic [7:0] octetOut;
  logic       fbitOut;

  int nChecks = 0, nFails = 0;
  expItem_t q[$];
  logic [3:0] mBuf = 4'b0000;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  tx_chan_cond u0 (.*);

  task automatic judge(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the model's result
  task automatic drive(logic e1, logic ab, logic frz, logic asg, logic idl,
                       logic zse, logic fv, logic upd, logic [3:0] si,
                       logic [7:0] oi, logic fi, string tag);
    expItem_t it;
    logic [3:0] show;
    @(negedge clk);
    modeE1 = e1; abOnly = ab; sigFreeze = frz; slotAssigned = asg;
    slotIdle = idl; zeroSupEn = zse; fbitVal = fv; sigUpd = upd;
    sigIn = si; octetIn = oi; fbitIn = fi;
    if (upd) begin
      if (!e1)     mBuf = {si[3:2], mBuf[1:0]};
      else if (ab) mBuf = {si[3:2], 2'b01};
      else         mBuf = si;
    end
    show = (!e1 && frz) ? {mBuf[3:2], mBuf[3:2]} : mBuf;
    it.sig = show;
    it.oct = (!e1 && asg && zse && oi == 8'h00) ? 8'h02 : oi;
    it.fb  = (!e1 && !asg && idl) ? fv : fi;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares just after each edge
  always @(posedge clk) begin
    #1;
    if (rstN && q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      judge(it.tag, "sigOut",   int'(sigOut),   int'(it.sig));
      judge(it.tag, "octetOut", int'(octetOut), int'(it.oct));
      judge(it.tag, "fbitOut",  int'(fbitOut),  int'(it.fb));
    end
  end

  initial begin
    #(CLK_PER*5000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    sigIn = 4'hF;
    #(CLK_PER*2 + 3);
    judge("R5", "reset sigOut", int'(sigOut), 0);
    @(negedge clk); rstN = 1;
    // R1 T1 loads AB only
    drive(0,0,0,1,0,0,0,1,4'b1010,8'h55,0,"R1");
    drive(0,0,0,1,0,0,0,1,4'b0111,8'h55,0,"R1");
    // R5 no strobe, input changes
    drive(0,0,0,1,0,0,0,0,4'b1111,8'h55,0,"R5");
    // R2 freeze mirror, then freeze + update same cycle
    drive(0,0,1,1,0,0,0,0,4'b0000,8'h33,0,"R2");
    drive(0,0,1,1,0,1,0,1,4'b1100,8'h00,0,"R2 R6");
    drive(0,0,0,1,0,0,0,0,4'b0000,8'h33,0,"R2");
    // R4 E1 full, freeze ignored
    drive(1,0,0,1,0,0,0,1,4'b0110,8'h00,1,"R4");
    drive(1,0,1,1,0,1,0,0,4'b1001,8'h00,1,"R4 R8");
    // R3 E1 AB only
    drive(1,1,0,1,0,0,0,1,4'b1110,8'h11,0,"R3");
    drive(1,1,0,0,1,0,1,0,4'b0000,8'h11,0,"R5 R8");
    // R6 zero substitution cases
    drive(0,0,0,1,0,1,0,0,4'b0000,8'h00,0,"R6");
    drive(0,0,0,1,0,0,0,0,4'b0000,8'h00,0,"R6");
    drive(0,0,0,1,0,1,0,0,4'b0000,8'h80,0,"R6");
    drive(0,0,0,0,0,1,0,0,4'b0000,8'h00,0,"R6");
    // R7 F-bit override
    drive(0,0,0,0,1,0,1,0,4'b0000,8'h7E,0,"R7");
    drive(0,0,0,0,1,0,0,0,4'b0000,8'h7E,1,"R7");
    drive(0,0,0,1,1,0,0,0,4'b0000,8'h7E,1,"R7");
    drive(0,0,0,0,0,0,0,0,4'b0000,8'h7E,1,"R7");
    drive(1,0,0,0,1,1,0,0,4'b0000,8'h00,1,"R8");
    @(negedge clk);
    // R9 combinational: change octet mid-cycle, look before next edge
    octetIn = 8'h00; modeE1 = 0; slotAssigned = 1; zeroSupEn = 1;
    #1 judge("R9", "octetOut same cycle", int'(octetOut), 8'h02);
    slotAssigned = 0; slotIdle = 1; fbitVal = 1; fbitIn = 0;
    #1 judge("R9", "fbitOut same cycle", int'(fbitOut), 1);
    @(posedge clk); #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule